// File: doc/BRIEF.md
# Serial Register Access Front End

This block is the serial slave side of a small radio controller. An external master drives a mode-0 serial bus: the clock idles low, bits are taken in on its rising edge, the output changes on its falling edge, and bytes travel most significant bit first. The serial clock, the active-low select and the data input are brought into the system clock domain through a synchronizer. The first byte after select goes low is a header. Bit 7 of the header is the read flag, bit 6 is the burst flag, and bits 5:0 are an address. The header steers the transaction to one of these targets: a 48-entry configuration register file, fourteen read-only status values, fourteen command strobes, an 8-entry power table, or the transmit FIFO write port.

For every byte the master sends, the block returns one byte on MISO. That byte is read data when the access is a read. In every other case it is the status byte that the surrounding logic supplies. In burst mode an internal address counter advances after each byte, and the burst lasts until select goes high. A single access ends after one data byte, and a strobe has no data byte at all. In both cases the next byte is a new header, and select does not have to be raised. Most strobes pulse at once. Two strobes are held back and pulse only when select rises.

Top module: `spi_regctl`

## Requirements
- R1: The byte returned during every header equals `status_i`. MISO changes only after a falling serial clock edge or an edge of select, and it is 0 while select is high.
- R2: A header with address 0x00–0x2F, read flag 0 and burst flag 0 writes one data byte into that configuration register. The same header with read flag 1 returns the register's value during the following byte.
- R3: A burst write (bit 6 set) stores consecutive bytes at consecutive configuration addresses, starting at the header address, until select rises.
- R4: A burst read (bits 7 and 6 set) returns the registers at consecutive configuration addresses, one per byte, starting at the header address.
- R5: A burst that passes address 0x2F stops at that point. Further writes in the burst are discarded, further reads return 0x00, and no register below 0x30 is touched again.
- R6: A header with address 0x30–0x3D and bit 6 set returns status value number (address − 0x30) during one data byte. The byte after that is parsed as a new header.
- R7: A header with address 0x30–0x3D and bit 6 clear is a strobe. It carries no data byte, it gives a one-cycle pulse on `strobe_o[address − 0x30]` before select rises, and the next byte is a header.
- R8: The strobes at addresses 0x32 and 0x39 are latched, not pulsed, and each pulses once in the cycle after select rises.
- R9: Header 0x3F gives one FIFO write and header 0x7F gives a FIFO write for every following byte. Each write is a one-cycle `fifo_we_o` pulse carrying that byte. With the read flag set, FIFO data bytes are discarded.
- R10: Address 0x3E reaches the 8-entry power table through an index that starts at 0 each time select falls. The index advances after each data byte, read or write, and wraps from 7 back to 0.
- R11: During each data byte of a write (to configuration, table or FIFO), the byte returned is `status_i`.
- R12: After reset every configuration and table entry is 0x00, no strobe or FIFO pulse is active, and MISO is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock from the master, idle low |
| csn_i | input | 1 | Active-low select from the master |
| mosi_i | input | 1 | Serial data in |
| miso_o | output | 1 | Serial data out |
| status_i | input | 8 | Status byte returned on header and write bytes |
| stat_vals_i | input | 112 | Fourteen read-only status values, entry k at bits 8k+7:8k |
| cfg_o | output | 384 | Configuration registers, entry k at bits 8k+7:8k |
| pa_o | output | 64 | Power table, entry k at bits 8k+7:8k |
| strobe_o | output | 14 | Strobe pulses, bit k for address 0x30+k |
| fifo_we_o | output | 1 | FIFO write pulse |
| fifo_data_o | output | 8 | FIFO write data |

## Verification
The bench runs bursts across the 0x2F boundary. A counter that does not stop there would fill the status window and then wrap, corrupting register 0x00 or returning stale data. Strobes are sent back to back with register accesses under one select. A design that expects a data byte after a strobe would misparse the next header. The two latched strobes are mixed with an immediate one: firing them early would put them ahead of the immediate pulse in the scoreboard. Status reads, FIFO headers with the read flag set, and single table accesses are each followed by a header in the same frame, which catches a design that leaves the data phase late or takes writes it should ignore.

// File: rtl/spi_regctl_pkg.sv
package spi_regctl_pkg;
   localparam int BYTE_W = 8;
   localparam int HDR_AW = 6;

   typedef struct packed {
      logic              rd;
      logic              burst;
      logic [HDR_AW-1:0] addr;
   } hdr_t;

   typedef enum logic [2:0] {
      K_NONE,
      K_CFG,
      K_STAT,
      K_PA,
      K_FIFO
   } acc_kind_t;

   typedef enum logic {
      PH_HDR,
      PH_DATA
   } phase_t;
endpackage

// File: rtl/spi_regctl_sync.sv
module spi_regctl_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sclk_i,
   input  logic csn_i,
   input  logic mosi_i,
   output logic sclk_rise,
   output logic sclk_fall,
   output logic cs_active,
   output logic cs_start,
   output logic cs_end,
   output logic mosi_s
);
   localparam int LANES = 3;
   localparam logic [LANES-1:0] IDLE = 3'b010;

   logic [STAGES*LANES-1:0] chain;
   logic [LANES-1:0]        last;
   logic [LANES-1:0]        prev;

   initial begin
      assert (STAGES >= 2) else $error("spi_regctl_sync: STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= {STAGES{IDLE}};
         prev  <= IDLE;
      end else begin
         chain <= {chain[(STAGES-1)*LANES-1:0], sclk_i, csn_i, mosi_i};
         prev  <= last;
      end
   end

   assign last      = chain[STAGES*LANES-1 -: LANES];
   assign sclk_rise = last[2] & ~prev[2];
   assign sclk_fall = ~last[2] & prev[2];
   assign cs_active = ~last[1];
   assign cs_start  = ~last[1] & prev[1];
   assign cs_end    = last[1] & ~prev[1];
   assign mosi_s    = last[0];
endmodule

// File: rtl/spi_regctl_shift.sv
module spi_regctl_shift #(
   parameter int BW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sclk_rise,
   input  logic          sclk_fall,
   input  logic          cs_active,
   input  logic          cs_start,
   input  logic          mosi_s,
   input  logic [BW-1:0] tx_byte,
   output logic          byte_done,
   output logic [BW-1:0] rx_byte,
   output logic          miso
);
   localparam int CW = $clog2(BW);
   localparam logic [CW-1:0] LAST = CW'(BW - 1);

   logic [CW-1:0] bit_cnt;
   logic [BW-1:0] rx_sh;
   logic [BW-1:0] tx_sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt   <= '0;
         rx_sh     <= '0;
         tx_sh     <= '0;
         rx_byte   <= '0;
         byte_done <= 1'b0;
      end else if (!cs_active) begin
         bit_cnt   <= '0;
         tx_sh     <= '0;
         byte_done <= 1'b0;
      end else begin
         byte_done <= 1'b0;
         if (cs_start) begin
            tx_sh <= tx_byte;
         end
         if (sclk_rise) begin
            rx_sh   <= {rx_sh[BW-2:0], mosi_s};
            bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt == LAST) begin
               byte_done <= 1'b1;
               rx_byte   <= {rx_sh[BW-2:0], mosi_s};
            end
         end
         if (sclk_fall) begin
            tx_sh <= (bit_cnt == '0) ? tx_byte : {tx_sh[BW-2:0], 1'b0};
         end
      end
   end

   assign miso = tx_sh[BW-1];
endmodule

// File: rtl/spi_regctl_regs.sv
module spi_regctl_regs #(
   parameter int NCFG = 48,
   parameter int NPA  = 8,
   parameter int BW   = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cfg_we,
   input  logic [5:0]             cfg_addr,
   input  logic                   pa_we,
   input  logic [$clog2(NPA)-1:0] pa_idx,
   input  logic [BW-1:0]          wdata,
   output logic [NCFG*BW-1:0]     cfg_q,
   output logic [NPA*BW-1:0]      pa_q
);
   localparam int IW = $clog2(NPA);

   for (genvar i = 0; i < NCFG; i++) begin : g_cfg
      logic [BW-1:0] r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            r <= '0;
         end else if (cfg_we && (cfg_addr == 6'(i))) begin
            r <= wdata;
         end
      end
      assign cfg_q[i*BW +: BW] = r;
   end

   for (genvar j = 0; j < NPA; j++) begin : g_pa
      logic [BW-1:0] r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            r <= '0;
         end else if (pa_we && (pa_idx == IW'(j))) begin
            r <= wdata;
         end
      end
      assign pa_q[j*BW +: BW] = r;
   end
endmodule

// File: rtl/spi_regctl.sv
module spi_regctl
   import spi_regctl_pkg::*;
#(
   parameter int               NCFG        = 48,
   parameter int               NSTAT       = 14,
   parameter int               NPA         = 8,
   parameter int               SYNC_STAGES = 2,
   parameter logic [NSTAT-1:0] DEFER_MASK  = 14'b00_0010_0000_0100
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   sclk_i,
   input  logic                   csn_i,
   input  logic                   mosi_i,
   output logic                   miso_o,
   input  logic [BYTE_W-1:0]      status_i,
   input  logic [NSTAT*BYTE_W-1:0] stat_vals_i,
   output logic [NCFG*BYTE_W-1:0] cfg_o,
   output logic [NPA*BYTE_W-1:0]  pa_o,
   output logic [NSTAT-1:0]       strobe_o,
   output logic                   fifo_we_o,
   output logic [BYTE_W-1:0]      fifo_data_o
);
   localparam int IW = $clog2(NPA);
   localparam logic [HDR_AW-1:0] CFG_END  = HDR_AW'(NCFG);
   localparam logic [HDR_AW-1:0] PA_ADDR  = HDR_AW'(NCFG + NSTAT);

   initial begin
      assert (NCFG + NSTAT + 2 == (1 << HDR_AW))
         else $error("spi_regctl: address map must fill the 6-bit header space");
      assert (NPA == (1 << IW)) else $error("spi_regctl: NPA must be a power of two");
   end

   logic sclk_rise, sclk_fall, cs_active, cs_start, cs_end, mosi_s;
   logic byte_done;
   logic [BYTE_W-1:0] rx_byte;
   logic [BYTE_W-1:0] tx_next;

   spi_regctl_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .sclk_i(sclk_i), .csn_i(csn_i), .mosi_i(mosi_i),
      .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .cs_active(cs_active),
      .cs_start(cs_start), .cs_end(cs_end), .mosi_s(mosi_s)
   );

   spi_regctl_shift #(.BW(BYTE_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
      .cs_active(cs_active), .cs_start(cs_start), .mosi_s(mosi_s),
      .tx_byte(tx_next), .byte_done(byte_done), .rx_byte(rx_byte), .miso(miso_o)
   );

   hdr_t            hdr;
   phase_t          phase;
   acc_kind_t       kind;
   logic            rd_q, burst_q;
   logic [HDR_AW-1:0] addr_q;
   logic [IW-1:0]   pa_idx;
   logic [NSTAT-1:0] pend;
   logic            data_byte, cfg_we, pa_we;

   assign hdr       = hdr_t'(rx_byte);
   assign data_byte = byte_done & cs_active & (phase == PH_DATA);
   assign cfg_we    = data_byte & ~rd_q & (kind == K_CFG) & (addr_q < CFG_END);
   assign pa_we     = data_byte & ~rd_q & (kind == K_PA);

   spi_regctl_regs #(.NCFG(NCFG), .NPA(NPA), .BW(BYTE_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(addr_q),
      .pa_we(pa_we), .pa_idx(pa_idx), .wdata(rx_byte), .cfg_q(cfg_o), .pa_q(pa_o)
   );

   // Read-side lookups: during a header the header address, otherwise the next slot.
   logic [HDR_AW-1:0] rd_addr, nxt_addr;
   logic [IW-1:0]     rd_idx;
   logic [BYTE_W-1:0] cfg_rd, pa_rd, stat_rd;

   assign nxt_addr = (addr_q < CFG_END) ? addr_q + 6'd1 : addr_q;
   assign rd_addr  = (phase == PH_HDR) ? hdr.addr : nxt_addr;
   assign rd_idx   = (phase == PH_HDR) ? pa_idx : pa_idx + 1'b1;

   always_comb begin
      cfg_rd = '0;
      for (int i = 0; i < NCFG; i++) begin
         if (rd_addr == 6'(i)) cfg_rd = cfg_o[i*BYTE_W +: BYTE_W];
      end
      pa_rd = '0;
      for (int j = 0; j < NPA; j++) begin
         if (rd_idx == IW'(j)) pa_rd = pa_o[j*BYTE_W +: BYTE_W];
      end
      stat_rd = '0;
      for (int k = 0; k < NSTAT; k++) begin
         if (hdr.addr == 6'(NCFG + k)) stat_rd = stat_vals_i[k*BYTE_W +: BYTE_W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase       <= PH_HDR;
         kind        <= K_NONE;
         rd_q        <= 1'b0;
         burst_q     <= 1'b0;
         addr_q      <= '0;
         pa_idx      <= '0;
         pend        <= '0;
         tx_next     <= '0;
         strobe_o    <= '0;
         fifo_we_o   <= 1'b0;
         fifo_data_o <= '0;
      end else begin
         strobe_o  <= '0;
         fifo_we_o <= 1'b0;
         if (cs_end) begin
            phase    <= PH_HDR;
            pa_idx   <= '0;
            strobe_o <= pend;
            pend     <= '0;
            tx_next  <= status_i;
         end else if (!cs_active) begin
            phase   <= PH_HDR;
            pa_idx  <= '0;
            tx_next <= status_i;
         end else if (byte_done) begin
            tx_next <= status_i;
            if (phase == PH_HDR) begin
               rd_q    <= hdr.rd;
               burst_q <= hdr.burst;
               addr_q  <= hdr.addr;
               if (hdr.addr < CFG_END) begin
                  phase <= PH_DATA;
                  kind  <= K_CFG;
                  if (hdr.rd) tx_next <= cfg_rd;
               end else if (hdr.addr < PA_ADDR) begin
                  if (hdr.burst) begin
                     phase   <= PH_DATA;
                     kind    <= K_STAT;
                     burst_q <= 1'b0;
                     tx_next <= stat_rd;
                  end else begin
                     kind <= K_NONE;
                     for (int k = 0; k < NSTAT; k++) begin
                        if (hdr.addr == 6'(NCFG + k)) begin
                           if (DEFER_MASK[k]) pend[k] <= 1'b1;
                           else               strobe_o[k] <= 1'b1;
                        end
                     end
                  end
               end else if (hdr.addr == PA_ADDR) begin
                  phase <= PH_DATA;
                  kind  <= K_PA;
                  if (hdr.rd) tx_next <= pa_rd;
               end else begin
                  phase <= PH_DATA;
                  kind  <= K_FIFO;
               end
            end else begin
               if (!rd_q && kind == K_FIFO) begin
                  fifo_we_o   <= 1'b1;
                  fifo_data_o <= rx_byte;
               end
               if (kind == K_PA) pa_idx <= pa_idx + 1'b1;
               if (burst_q) begin
                  addr_q <= nxt_addr;
                  if (rd_q && kind == K_CFG) tx_next <= cfg_rd;
                  if (rd_q && kind == K_PA)  tx_next <= pa_rd;
               end else begin
                  phase <= PH_HDR;
               end
            end
         end
      end
   end
endmodule

// File: rtl/spi_regctl_chk.sv
module spi_regctl_chk #(
   parameter int               NCFG       = 48,
   parameter int               NSTAT      = 14,
   parameter logic [NSTAT-1:0] DEFER_MASK = '0
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 cs_end,
   input logic                 cs_start,
   input logic                 sclk_fall,
   input logic                 byte_done,
   input logic                 miso,
   input logic [NSTAT-1:0]     strobe,
   input logic                 fifo_we,
   input logic [NCFG*8-1:0]    cfg
);
   // R1: MISO moves only after a falling serial clock or a select edge
   p_miso_moves_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(miso) |-> $past(sclk_fall || cs_start || cs_end));

   // R2: configuration contents change only right after a completed byte
   p_cfg_on_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg != $past(cfg)) |-> $past(byte_done));

   // R7: strobe pulses last a single cycle
   p_strobe_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (|strobe) |=> (strobe == '0));

   // R8: latched strobes appear only after select has risen
   p_defer_after_cs_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (|(strobe & DEFER_MASK)) |-> $past(cs_end));

   // R9: FIFO write pulses last a single cycle
   p_fifo_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_we |=> !fifo_we);
endmodule

bind spi_regctl spi_regctl_chk #(
   .NCFG(NCFG), .NSTAT(NSTAT), .DEFER_MASK(DEFER_MASK)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cs_end(cs_end), .cs_start(cs_start),
   .sclk_fall(sclk_fall), .byte_done(byte_done), .miso(miso_o),
   .strobe(strobe_o), .fifo_we(fifo_we_o), .cfg(cfg_o)
);

// File: tb/spi_regctl_tb.sv
module spi_regctl_tb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sclk = 1'b0, csn = 1'b1, mosi = 1'b0;
   logic miso;
   logic [7:0]   status;
   logic [111:0] stat_vals;
   logic [383:0] cfg_o;
   logic [63:0]  pa_o;
   logic [13:0]  strobe_o;
   logic         fifo_we;
   logic [7:0]   fifo_data;

   always #2 clk = ~clk;

   spi_regctl u_dut (
      .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .csn_i(csn), .mosi_i(mosi),
      .miso_o(miso), .status_i(status), .stat_vals_i(stat_vals), .cfg_o(cfg_o),
      .pa_o(pa_o), .strobe_o(strobe_o), .fifo_we_o(fifo_we), .fifo_data_o(fifo_data)
   );

   int checks = 0;
   int bad = 0;
   bit finished = 0;
   logic [15:0] sb_q[$];
   logic [7:0]  cfg_m[48];
   logic [7:0]  pa_m[8];

   task automatic chk8(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic chk_cfg(input string req);
      bit ok = 1;
      checks++;
      for (int i = 0; i < 48; i++) begin
         if (cfg_o[i*8 +: 8] !== cfg_m[i]) begin
            ok = 0;
            $display("FAIL %s cfg[%0d] actual=%h expected=%h", req, i, cfg_o[i*8 +: 8], cfg_m[i]);
         end
      end
      if (!ok) bad++;
   endtask

   task automatic chk_pa(input string req);
      bit ok = 1;
      checks++;
      for (int i = 0; i < 8; i++) begin
         if (pa_o[i*8 +: 8] !== pa_m[i]) begin
            ok = 0;
            $display("FAIL %s pa[%0d] actual=%h expected=%h", req, i, pa_o[i*8 +: 8], pa_m[i]);
         end
      end
      if (!ok) bad++;
   endtask

   task automatic chk_sb_empty(input string req);
      checks++;
      if (sb_q.size() != 0) begin
         bad++;
         $display("FAIL %s pending events actual=%0d expected=0", req, sb_q.size());
      end
   endtask

   // Monitor: pops expected pulses and compares them with what the design emits.
   task automatic seen(input logic [15:0] got);
      logic [15:0] exp;
      checks++;
      if (sb_q.size() == 0) begin
         bad++;
         $display("FAIL %s unexpected event actual=%h expected=none",
                  (got[15:8] == 8'hF0) ? "R9" : "R7/R8", got);
      end else begin
         exp = sb_q.pop_front();
         if (exp !== got) begin
            bad++;
            $display("FAIL %s event actual=%h expected=%h",
                     (exp[15:8] == 8'hF0) ? "R9" : "R7/R8", got, exp);
         end
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         if (fifo_we) seen({8'hF0, fifo_data});
         for (int i = 0; i < 14; i++) begin
            if (strobe_o[i]) seen({8'hA0, 8'(i)});
         end
      end
   end

   task automatic xfer(input logic [7:0] b, output logic [7:0] r);
      for (int i = 7; i >= 0; i--) begin
         @(negedge clk) mosi = b[i];
         repeat (8) @(negedge clk);
         sclk = 1'b1;
         r[i] = miso;
         repeat (8) @(negedge clk);
         sclk = 1'b0;
      end
   endtask

   task automatic cs_lo();
      @(negedge clk) csn = 1'b0;
      repeat (8) @(negedge clk);
   endtask

   task automatic cs_hi();
      repeat (8) @(negedge clk);
      csn = 1'b1;
      repeat (12) @(negedge clk);
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("  test done: total=%0d bad=%0d", checks, bad);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
   end

   initial begin
      logic [7:0] r;
      status = 8'h5A;
      for (int i = 0; i < 14; i++) stat_vals[i*8 +: 8] = 8'(8'h80 + i * 3);
      for (int i = 0; i < 48; i++) cfg_m[i] = 8'h00;
      for (int i = 0; i < 8; i++)  pa_m[i]  = 8'h00;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      // R12: reset state
      chk8("R12 miso", {7'd0, miso}, 8'h00);
      chk8("R12 strobe", {7'd0, |strobe_o}, 8'h00);
      chk8("R12 fifo_we", {7'd0, fifo_we}, 8'h00);
      chk_cfg("R12");
      chk_pa("R12");

      // R2 single write and read back; R1 header status; R11 write status
      cs_lo();
      xfer(8'h05, r); chk8("R1 header status", r, 8'h5A);
      xfer(8'hC3, r); chk8("R11 write status", r, 8'h5A);
      cfg_m[5] = 8'hC3;
      xfer(8'h85, r); chk8("R1 second header", r, 8'h5A);
      xfer(8'h00, r); chk8("R2 single read", r, 8'hC3);
      cs_hi();
      chk_cfg("R2");

      // R3 burst write across 0x2F; R5 tail discarded
      cs_lo();
      xfer(8'h6D, r);
      xfer(8'h11, r); xfer(8'h22, r); xfer(8'h33, r); xfer(8'h44, r); xfer(8'h55, r);
      cs_hi();
      cfg_m[45] = 8'h11; cfg_m[46] = 8'h22; cfg_m[47] = 8'h33;
      chk_cfg("R3/R5");

      // R4 burst read; R5 reads past the end are zero
      cs_lo();
      xfer(8'hEE, r);
      xfer(8'h00, r); chk8("R4 burst rd0", r, 8'h22);
      xfer(8'h00, r); chk8("R4 burst rd1", r, 8'h33);
      xfer(8'h00, r); chk8("R5 past end", r, 8'h00);
      xfer(8'h00, r); chk8("R5 past end2", r, 8'h00);
      cs_hi();
      cs_lo();
      xfer(8'hC4, r);
      xfer(8'h00, r); chk8("R4 rd 0x04", r, 8'h00);
      xfer(8'h00, r); chk8("R4 rd 0x05", r, 8'hC3);
      xfer(8'h00, r); chk8("R4 rd 0x06", r, 8'h00);
      cs_hi();

      // R6 status reads, next byte is a header
      cs_lo();
      xfer(8'hF3, r); chk8("R1 status hdr", r, 8'h5A);
      xfer(8'h00, r); chk8("R6 status 3", r, 8'h89);
      xfer(8'h85, r); chk8("R6 header after", r, 8'h5A);
      xfer(8'h00, r); chk8("R6 read after", r, 8'hC3);
      xfer(8'h7D, r);
      xfer(8'h00, r); chk8("R6 status 13", r, 8'hA7);
      cs_hi();

      // R7 immediate strobes followed by a header in the same frame
      cs_lo();
      sb_q.push_back({8'hA0, 8'd4});
      xfer(8'h34, r);
      sb_q.push_back({8'hA0, 8'd13});
      xfer(8'h3D, r);
      xfer(8'h06, r);
      xfer(8'h99, r);
      repeat (4) @(negedge clk);
      chk_sb_empty("R7 before cs high");
      cs_hi();
      cfg_m[6] = 8'h99;
      chk_cfg("R7 header after strobe");

      // R8 latched strobes
      cs_lo();
      sb_q.push_back({8'hA0, 8'd0});
      xfer(8'h39, r);
      xfer(8'h32, r);
      xfer(8'h30, r);
      repeat (4) @(negedge clk);
      chk_sb_empty("R8 immediate only");
      sb_q.push_back({8'hA0, 8'd2});
      sb_q.push_back({8'hA0, 8'd9});
      cs_hi();
      chk_sb_empty("R8 after cs high");

      // R9 FIFO single and burst; R11 status on FIFO data
      cs_lo();
      xfer(8'h3F, r);
      sb_q.push_back({8'hF0, 8'hAB});
      xfer(8'hAB, r); chk8("R11 fifo status", r, 8'h5A);
      xfer(8'h7F, r);
      sb_q.push_back({8'hF0, 8'h01});
      sb_q.push_back({8'hF0, 8'h02});
      sb_q.push_back({8'hF0, 8'h03});
      xfer(8'h01, r); xfer(8'h02, r); xfer(8'h03, r);
      cs_hi();
      chk_sb_empty("R9 fifo writes");
      cs_lo();
      xfer(8'hBF, r);
      xfer(8'hEE, r);
      xfer(8'h85, r);
      xfer(8'h00, r); chk8("R9 header after fifo read", r, 8'hC3);
      cs_hi();
      chk_sb_empty("R9 fifo read ignored");

      // R10 power table burst with wrap, read from index 0, single accesses
      cs_lo();
      xfer(8'h7E, r);
      for (int i = 0; i < 8; i++) begin
         xfer(8'(8'h10 + i * 7), r);
         pa_m[i] = 8'(8'h10 + i * 7);
      end
      xfer(8'hF1, r);
      pa_m[0] = 8'hF1;
      cs_hi();
      chk_pa("R10 burst wrap");
      cs_lo();
      xfer(8'hFE, r);
      xfer(8'h00, r); chk8("R10 rd idx0", r, pa_m[0]);
      xfer(8'h00, r); chk8("R10 rd idx1", r, pa_m[1]);
      xfer(8'h00, r); chk8("R10 rd idx2", r, pa_m[2]);
      cs_hi();
      cs_lo();
      xfer(8'h3E, r);
      xfer(8'h66, r);
      pa_m[0] = 8'h66;
      xfer(8'hBE, r);
      xfer(8'h00, r); chk8("R10 single idx advance", r, pa_m[1]);
      cs_hi();
      chk_pa("R10 single write");
      chk8("R1 miso idle", {7'd0, miso}, 8'h00);
      chk_sb_empty("R7/R9 final");

      summary();
   end
endmodule